// File: doc/BRIEF.md
# Priority-based reference clock selector

This block chooses one of fourteen candidate reference inputs for a clock path. Each candidate has a qualified flag, which is produced elsewhere, and a 4-bit programmable priority. From these the block keeps a registered ranking of the three best eligible candidates. It also keeps a registered selection that follows one of two policies, chosen by a mode input. In revertive mode the selection always tracks the best candidate. In non-revertive mode the selection stays on its current input until that input becomes ineligible.

When no candidate is eligible, the block raises a status flag. If the interrupt enable is set, it also raises a sticky interrupt, which software clears with a one-cycle clear pulse.

Inputs are numbered 1 to 14. Index code 0 means "no input".

Top module: `refclk_selector`

## Requirements
- R1: While reset is asserted, and in the first sampling after it, the selected index, all three ranked indices, the lost flag and the interrupt read 0.
- R2: An input n is eligible when qual_i[n-1] is 1 and its priority field prio_i[4n-1:4n-4] is nonzero. A smaller nonzero value means a higher priority. rank1_o, rank2_o and rank3_o report the three best eligible inputs as index codes 1 to 14, one clock after the inputs are applied.
- R3: When eligible inputs share a priority, the smaller index ranks first, both in the ranking and in the selection.
- R4: An input with priority 0 is never ranked or selected, even if it is qualified. A ranking slot that has no eligible candidate reads 0.
- R5: In non-revertive mode (revertive_i = 0), a selected input that stays eligible is kept, even when a better input becomes eligible.
- R6: In non-revertive mode, when the selected input becomes ineligible, the next selection is the best eligible input.
- R7: In revertive mode (revertive_i = 1), sel_idx_o equals the best eligible input one clock after the inputs are applied.
- R8: When no input is eligible, all_lost_o reads 1 and sel_idx_o reads 0, one clock later. all_lost_o reads 0 otherwise.
- R9: irq_o is set in the same cycle that all_lost_o goes from 0 to 1, but only if irq_en_i was 1. It then stays set until a cycle with irq_clr_i = 1 and no new rising of all_lost_o. A new rising in that cycle wins over the clear. With irq_en_i = 0, irq_o never sets.
- R10: When eligibility returns after all inputs were lost, the selection is the best eligible input in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qual_i | input | 14 | Qualified flag per input; bit n-1 is input n |
| prio_i | input | 56 | Priority fields; input n uses bits [4n-1:4n-4] |
| revertive_i | input | 1 | 1 = revertive, 0 = non-revertive |
| irq_en_i | input | 1 | Interrupt enable for the all-lost event |
| irq_clr_i | input | 1 | Write-one-to-clear pulse for irq_o |
| sel_idx_o | output | 4 | Selected input index, 0 = none |
| rank1_o | output | 4 | Best eligible input, 0 = none |
| rank2_o | output | 4 | Second best eligible input, 0 = none |
| rank3_o | output | 4 | Third best eligible input, 0 = none |
| all_lost_o | output | 1 | No input is eligible |
| irq_o | output | 1 | Sticky all-lost interrupt |

## Verification
The bench runs directed scenarios and a long pseudo-random sweep of qualification, priority and mode patterns. Each result is compared against a model that ranks the inputs by scanning priority values in order, so a design that breaks ties toward the larger index, or that ranks a qualified input with priority 0, produces wrong ranked codes at once. Directed cases cover the following:
- A better input appearing in non-revertive mode. A selector that reverts anyway jumps to that input.
- The current input being dropped. A selector that freezes keeps a stale index.
- Recovery from the all-lost state, where a stuck selection stays at 0.
- The interrupt enable and the clear pulse, including a clear in the same cycle as a new loss. A design that lets the clear win would lose that event.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
   localparam int unsigned NUM_RANK = 3;

   function automatic int unsigned idx_width(input int unsigned n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/refsel_slot.sv
module refsel_slot #(
   parameter int unsigned N_IN   = 14,
   parameter int unsigned PRIO_W = 4,
   parameter int unsigned IDX_W  = 4
) (
   input  logic [N_IN-1:0]        avail_i,
   input  logic [N_IN*PRIO_W-1:0] prio_i,
   output logic [IDX_W-1:0]       idx_o,
   output logic [N_IN-1:0]        avail_o
);
   logic              found;
   logic [PRIO_W-1:0] best_p;
   logic [N_IN-1:0]   taken;

   always_comb begin
      found  = 1'b0;
      best_p = '0;
      idx_o  = '0;
      taken  = '0;
      for (int k = 0; k < N_IN; k++) begin
         if (avail_i[k] && (!found || prio_i[k*PRIO_W +: PRIO_W] < best_p)) begin
            found  = 1'b1;
            best_p = prio_i[k*PRIO_W +: PRIO_W];
            idx_o  = IDX_W'(k + 1);
            taken  = '0;
            taken[k] = 1'b1;
         end
      end
      avail_o = avail_i & ~taken;
   end
endmodule

// File: rtl/refsel_rank.sv
module refsel_rank #(
   parameter int unsigned N_IN   = 14,
   parameter int unsigned PRIO_W = 4,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned N_RANK = 3
) (
   input  logic [N_IN-1:0]         qual_i,
   input  logic [N_IN*PRIO_W-1:0]  prio_i,
   output logic [N_IN-1:0]         elig_o,
   output logic [N_RANK*IDX_W-1:0] rank_o
);
   logic [N_IN-1:0] chain [N_RANK+1];

   for (genvar k = 0; k < N_IN; k++) begin : g_elig
      assign elig_o[k] = qual_i[k] && (prio_i[k*PRIO_W +: PRIO_W] != '0);
   end

   assign chain[0] = elig_o;

   for (genvar s = 0; s < N_RANK; s++) begin : g_slot
      refsel_slot #(.N_IN(N_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) slot_i (
         .avail_i (chain[s]),
         .prio_i  (prio_i),
         .idx_o   (rank_o[s*IDX_W +: IDX_W]),
         .avail_o (chain[s+1])
      );
   end

   // R3, R4: a later slot may only be filled when the earlier slot is filled
   // with a different input
   always_comb begin
      for (int s = 1; s < N_RANK; s++) begin
         if (rank_o[s*IDX_W +: IDX_W] != '0)
            a_r4_slot_order: assert (rank_o[(s-1)*IDX_W +: IDX_W] != '0 &&
                                     rank_o[(s-1)*IDX_W +: IDX_W] != rank_o[s*IDX_W +: IDX_W]);
      end
   end
endmodule

// File: rtl/refsel_hold.sv
module refsel_hold #(
   parameter int unsigned N_IN  = 14,
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             revertive_i,
   input  logic [N_IN-1:0]  elig_i,
   input  logic [IDX_W-1:0] best_i,
   output logic [IDX_W-1:0] sel_o
);
   logic cur_ok;

   always_comb begin
      cur_ok = 1'b0;
      for (int k = 0; k < N_IN; k++)
         if (sel_o == IDX_W'(k + 1) && elig_i[k]) cur_ok = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                       sel_o <= '0;
      else if (!revertive_i && cur_ok)  sel_o <= sel_o;
      else                              sel_o <= best_i;
   end

   a_r5_nonrev_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (!revertive_i && cur_ok) |=> (sel_o == $past(sel_o)));

   a_r6_leave_lost: assert property (@(posedge clk) disable iff (!rst_n)
      (!cur_ok && sel_o != '0) |=> (sel_o != $past(sel_o)));
endmodule

// File: rtl/refsel_alarm.sv
module refsel_alarm (
   input  logic clk,
   input  logic rst_n,
   input  logic none_i,
   input  logic irq_en_i,
   input  logic irq_clr_i,
   output logic lost_o,
   output logic irq_o
);
   logic rise;
   assign rise = none_i && !lost_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lost_o <= 1'b0;
         irq_o  <= 1'b0;
      end else begin
         lost_o <= none_i;
         irq_o  <= (irq_o && !irq_clr_i) || (rise && irq_en_i);
      end
   end

   a_r9_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && irq_en_i) |=> irq_o);

   a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !irq_clr_i) |=> irq_o);

   a_r9_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_o && !(rise && irq_en_i)) |=> !irq_o);
endmodule

// File: rtl/refclk_selector.sv
module refclk_selector #(
   parameter int unsigned N_IN   = 14,
   parameter int unsigned PRIO_W = 4,
   parameter int unsigned IDX_W  = refsel_pkg::idx_width(N_IN)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_IN-1:0]        qual_i,
   input  logic [N_IN*PRIO_W-1:0] prio_i,
   input  logic                   revertive_i,
   input  logic                   irq_en_i,
   input  logic                   irq_clr_i,
   output logic [IDX_W-1:0]       sel_idx_o,
   output logic [IDX_W-1:0]       rank1_o,
   output logic [IDX_W-1:0]       rank2_o,
   output logic [IDX_W-1:0]       rank3_o,
   output logic                   all_lost_o,
   output logic                   irq_o
);
   localparam int unsigned NR = refsel_pkg::NUM_RANK;

   if (N_IN < 1 || N_IN >= (1 << IDX_W)) begin : g_bad_idx
      $error("refclk_selector: IDX_W too narrow for N_IN");
   end
   if (PRIO_W < 1) begin : g_bad_prio
      $error("refclk_selector: PRIO_W must be at least 1");
   end

   logic [N_IN-1:0]     elig;
   logic [NR*IDX_W-1:0] rank_c;
   logic [NR*IDX_W-1:0] rank_q;

   refsel_rank #(.N_IN(N_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W), .N_RANK(NR)) rank_i (
      .qual_i (qual_i),
      .prio_i (prio_i),
      .elig_o (elig),
      .rank_o (rank_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) rank_q <= '0;
      else        rank_q <= rank_c;
   end

   assign rank1_o = rank_q[0*IDX_W +: IDX_W];
   assign rank2_o = rank_q[1*IDX_W +: IDX_W];
   assign rank3_o = rank_q[2*IDX_W +: IDX_W];

   refsel_hold #(.N_IN(N_IN), .IDX_W(IDX_W)) hold_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .revertive_i (revertive_i),
      .elig_i      (elig),
      .best_i      (rank_c[0 +: IDX_W]),
      .sel_o       (sel_idx_o)
   );

   refsel_alarm alarm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .none_i    (rank_c[0 +: IDX_W] == '0),
      .irq_en_i  (irq_en_i),
      .irq_clr_i (irq_clr_i),
      .lost_o    (all_lost_o),
      .irq_o     (irq_o)
   );

   a_r7_revert_match: assert property (@(posedge clk) disable iff (!rst_n)
      revertive_i |=> (sel_idx_o == rank1_o));

   a_r8_lost_empty: assert property (@(posedge clk) disable iff (!rst_n)
      all_lost_o |-> (sel_idx_o == '0 && rank1_o == '0));

   a_r10_recover_best: assert property (@(posedge clk) disable iff (!rst_n)
      (all_lost_o && rank_c[0 +: IDX_W] != '0) |=> (sel_idx_o == rank1_o && sel_idx_o != '0));
endmodule

// File: tb/refclk_selector_tb_top.sv
module refclk_selector_tb_top;
   localparam int N = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  qual = '0;
   logic [N*4-1:0] prio = '0;
   logic          rev = 1'b0;
   logic          en = 1'b0;
   logic          clr = 1'b0;
   logic [3:0]    sel, r1, r2, r3;
   logic          lost, irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   logic [3:0] e_sel = 0;
   logic       e_lost = 0;
   logic       e_irq = 0;

   always #2 clk = ~clk;

   refclk_selector dut_i (
      .clk(clk), .rst_n(rst_n), .qual_i(qual), .prio_i(prio),
      .revertive_i(rev), .irq_en_i(en), .irq_clr_i(clr),
      .sel_idx_o(sel), .rank1_o(r1), .rank2_o(r2), .rank3_o(r3),
      .all_lost_o(lost), .irq_o(irq)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [3:0] pr(input int n);
      return prio[(n-1)*4 +: 4];
   endfunction

   function automatic bit ok(input int n);
      return n >= 1 && qual[n-1] && pr(n) != 0;
   endfunction

   // ranking by scanning priority levels, then indices
   task automatic model_rank(output logic [3:0] a, output logic [3:0] b, output logic [3:0] c);
      int cnt = 0;
      a = 0; b = 0; c = 0;
      for (int p = 1; p < 16; p++)
         for (int i = 1; i <= N; i++)
            if (ok(i) && pr(i) == p) begin
               if (cnt == 0) a = i[3:0];
               else if (cnt == 1) b = i[3:0];
               else if (cnt == 2) c = i[3:0];
               cnt++;
            end
   endtask

   // inputs are driven at a negedge; registered outputs are sampled at the next negedge
   task automatic step(input string tag);
      logic [3:0] a, b, c, ns;
      logic nl;
      model_rank(a, b, c);
      ns = (!rev && e_sel != 0 && ok(e_sel)) ? e_sel : a;
      nl = (a == 0);
      e_irq = (e_irq && !clr) || (nl && !e_lost && en);
      e_lost = nl;
      e_sel = ns;
      @(posedge clk);
      @(negedge clk);
      check({tag, " R2 rank1"}, r1, a);
      check({tag, " R2 rank2"}, r2, b);
      check({tag, " R2 rank3"}, r3, c);
      check({tag, " sel"}, sel, ns);
      check({tag, " R8 lost"}, lost, nl);
      check({tag, " R9 irq"}, irq, e_irq);
   endtask

   task automatic setp(input int n, input int p);
      prio[(n-1)*4 +: 4] = p[3:0];
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] lf;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 sel", sel, 0); check("R1 rank1", r1, 0);
      check("R1 rank2", r2, 0); check("R1 rank3", r3, 0);
      check("R1 lost", lost, 0); check("R1 irq", irq, 0);
      rst_n = 1'b1;
      qual = '0; prio = '0; en = 1'b0;
      step("R1 first");
      check("R1 no irq without enable", irq, 0);

      // R3 ties: all priority 7, all qualified
      for (int i = 1; i <= N; i++) setp(i, 7);
      qual = '1;
      step("R3 tie");
      check("R3 tie rank1", r1, 1); check("R3 tie rank2", r2, 2); check("R3 tie rank3", r3, 3);

      // R2 distinct priorities, reverse order
      for (int i = 1; i <= N; i++) setp(i, 15 - i);
      rev = 1'b1;
      step("R2 desc");
      check("R2 desc rank1", r1, 14); check("R2 desc rank2", r2, 13);
      check("R7 revert tracks best", sel, 14);

      // R4 priority zero excluded, empty slots read 0
      for (int i = 1; i <= N; i++) setp(i, 0);
      setp(5, 3);
      qual = '1;
      step("R4 zero prio");
      check("R4 rank1", r1, 5); check("R4 rank2 empty", r2, 0); check("R4 rank3 empty", r3, 0);

      // R5 non-revertive keep
      rev = 1'b0;
      qual = 14'b0;  qual[4] = 1'b1;
      setp(5, 9);
      step("R5 setup");
      setp(2, 1); qual[1] = 1'b1;
      step("R5 better appears");
      check("R5 keeps current", sel, 5);
      check("R5 rank still moves", r1, 2);
      // R6 drop current
      qual[4] = 1'b0;
      step("R6 drop");
      check("R6 reselect best", sel, 2);
      // R7 revertive switch
      setp(5, 9); qual[4] = 1'b1; setp(2, 12);
      step("R7 pre");
      check("R5 no revert", sel, 2);
      rev = 1'b1;
      step("R7 switch");
      check("R7 switch to best", sel, 5);

      // R8/R9 all lost with enable
      en = 1'b1;
      qual = '0;
      step("R8 lost");
      check("R8 lost flag", lost, 1); check("R8 sel zero", sel, 0);
      check("R9 irq set", irq, 1);
      step("R9 hold");
      check("R9 irq sticky", irq, 1);
      clr = 1'b1;
      step("R9 clear");
      clr = 1'b0;
      check("R9 irq cleared", irq, 0);

      // R10 recovery in non-revertive mode
      rev = 1'b0;
      for (int i = 1; i <= N; i++) setp(i, 4);
      setp(9, 2);
      qual = '1;
      step("R10 recover");
      check("R10 recover best", sel, 9);

      // R9 clear coinciding with a new loss: set wins
      qual = '0; clr = 1'b1;
      step("R9 set over clear");
      clr = 1'b0;
      check("R9 set wins", irq, 1);
      en = 1'b0; clr = 1'b1; qual = '1;
      step("R9 clr2");
      clr = 1'b0; qual = '0;
      step("R9 no enable");
      check("R9 disabled no set", irq, 0);

      // sweep
      lf = 32'hACE1_1234;
      for (int it = 0; it < 3000; it++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         qual = (it % 7 == 3) ? '0 : lf[13:0];
         prio = {lf, lf[23:0]} ^ {24'(it), lf};
         if (it % 5 == 0) rev = lf[20];
         en = lf[25];
         clr = lf[26] & lf[27];
         step((it % 2) ? "R6 sweep" : "R7 sweep");
      end
      clr = 1'b0;

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule